// File: doc/BRIEF.md
# Register Writer Scoreboard

This block keeps, for every architectural register of an in-order pipeline, an ordered list of the instructions that still owe that register a result. Registers come in three classes (integer, floating-point, miscellaneous) and each register owns a short queue of writer sequence numbers. New writers join the tail of a queue, so each queue stays in program order. Writers leave the queue in one of two ways: a delete by tag that can take an entry from any position, or a pop that takes only the head.

A single command port carries one operation per cycle: insert a writer with up to two destinations, remove a writer by tag, pop a head entry, or report that a writer has produced its result (writeback). A separate query port is combinational and answers three questions for one register and one requesting sequence number. May the requester read the register? May it write the register? Is there an older writer whose finished result can be forwarded to it? Each queue entry holds its writer's executed status and the cycle its result appeared. That cycle comes from a free-running counter inside the block.

Top module: `rdt_scoreboard`

## Requirements
- R1: An accepted insert appends the command sequence number to the tail of the queue of each live destination. A destination is live when its valid bit is set, its class code is 0 (integer), 1 (floating-point) or 2 (miscellaneous), and it is not integer register 0. Class code 3 marks a destination as absent.
- R2: Integer register 0 is never tracked. Insert and remove skip it without an error, and its queue always reads as empty.
- R3: If both destinations of one insert or remove name the same register, the command acts on that register once.
- R4: `q_read_ok` is 1 when the queried register's queue is empty, or when `q_seq` is less than or equal to the head entry's sequence number. Otherwise it is 0. A query with class code 3 sees an empty queue.
- R5: `q_write_ok` follows the same rule as `q_read_ok`.
- R6: The forwarding candidate is found by scanning from the head and taking the last entry whose sequence number is strictly below `q_seq`. The scan stops at the first entry that is not below `q_seq`.
- R7: `q_fwd_valid` is 1 only when a candidate exists, that candidate has been reported by a writeback, and its result cycle is strictly earlier than the current cycle. `q_fwd_seq` then gives the candidate's sequence number; otherwise it is 0. A writeback (op 4) marks every matching entry that has not yet executed and stamps it with the current cycle.
- R8: Remove (op 2) deletes the matching entry from each live destination queue at whatever position it holds, and the entries behind it move forward. If any live destination lacks the tag, `cmd_err` is raised and no queue changes.
- R9: Pop (op 3) deletes the head of the destination-0 queue. If that queue is empty, if its head does not equal `cmd_seq`, or if destination 0 is invalid or has class code 3, `cmd_err` is raised and nothing changes.
- R10: Insert (op 1) raises `ins_tracked` when it adds at least one entry. A remove with `cmd_tracked` = 0 does nothing and raises neither `cmd_err` nor `rm_clear`. A successful tracked remove raises `rm_clear`.
- R11: An insert that finds any live destination queue holding DEPTH entries raises `ins_stall` and changes no state.
- R12: `ins_stall`, `ins_tracked`, `rm_clear`, `cmd_err` and all query outputs are combinational in the cycle the command or query is presented. The state change a command makes is seen by queries from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | 0 none, 1 insert, 2 remove, 3 pop, 4 writeback |
| cmd_seq | input | SEQ_W | Sequence number the command refers to |
| cmd_tracked | input | 1 | Instruction holds entries (remove only) |
| d0_valid | input | 1 | Destination 0 present |
| d0_cls | input | 2 | Destination 0 register class |
| d0_idx | input | log2(NREG) | Destination 0 register index |
| d1_valid | input | 1 | Destination 1 present |
| d1_cls | input | 2 | Destination 1 register class |
| d1_idx | input | log2(NREG) | Destination 1 register index |
| q_seq | input | SEQ_W | Requester sequence number for the query |
| q_cls | input | 2 | Queried register class |
| q_idx | input | log2(NREG) | Queried register index |
| ins_stall | output | 1 | Insert refused because a queue is full |
| ins_tracked | output | 1 | Insert added at least one entry |
| rm_clear | output | 1 | Tracked remove completed |
| cmd_err | output | 1 | Remove or pop failed to find its entry |
| q_read_ok | output | 1 | Requester may read the register |
| q_write_ok | output | 1 | Requester may write the register |
| q_fwd_valid | output | 1 | A finished older writer can forward |
| q_fwd_seq | output | SEQ_W | Sequence number of that writer |

## Verification
The command flags and all query answers are due in the cycle their inputs are presented. Queue contents, executed bits and result cycles only change at the next rising edge. So a query made in the same cycle as a command still sees the old state, and forwarding from a writer becomes valid one cycle after its writeback at the earliest. The bench drives each step just after a falling edge and samples every output one nanosecond later, before any edge. It advances its reference queues and cycle count only at the rising edge. Every output is compared to the model on every step.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    parameter int SEQ_W   = 8;
    parameter int TIME_W  = 32;
    parameter int NUM_CLS = 3;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_INSERT = 3'd1,
        OP_REMOVE = 3'd2,
        OP_POP    = 3'd3,
        OP_WBACK  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_MISC = 2'd2
    } cls_e;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic              done;
        logic [TIME_W-1:0] rtime;
    } wr_ent_t;

    // A destination takes part in tracking when present, in a real class,
    // and not the hardwired integer zero register.
    function automatic logic dest_live(logic v, logic [1:0] cls, logic idx_zero);
        return v && (cls < 2'(NUM_CLS)) && !((cls == CLS_INT) && idx_zero);
    endfunction
endpackage

// File: rtl/rdt_wq.sv
module rdt_wq
    import rdt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ins_en,
    input  logic                    del_en,
    input  logic                    wb_en,
    input  logic [SEQ_W-1:0]        tag,
    input  logic [TIME_W-1:0]       now,
    output wr_ent_t [DEPTH-1:0]     ent_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    full_o,
    output logic                    hit_o,
    output logic                    head_hit_o
);
    wr_ent_t [DEPTH-1:0] ent_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    pos;

    always_comb begin
        hit_o = 1'b0;
        pos   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit_o && (CNT_W'(i) < cnt_q) && (ent_q[i].seq == tag)) begin
                hit_o = 1'b1;
                pos   = CNT_W'(i);
            end
        end
    end

    assign head_hit_o = (cnt_q != '0) && (ent_q[0].seq == tag);
    assign full_o     = (cnt_q == CNT_W'(DEPTH));
    assign ent_o      = ent_q;
    assign cnt_o      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ent_q <= '0;
        end else if (ins_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_q) ent_q[i] <= '{seq: tag, done: 1'b0, rtime: '0};
            cnt_q <= cnt_q + 1'b1;
        end else if (del_en) begin
            for (int i = 0; i < DEPTH - 1; i++)
                if (CNT_W'(i) >= pos) ent_q[i] <= ent_q[i+1];
            ent_q[DEPTH-1] <= '0;
            cnt_q <= cnt_q - 1'b1;
        end else if (wb_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((CNT_W'(i) < cnt_q) && (ent_q[i].seq == tag) && !ent_q[i].done) begin
                    ent_q[i].done  <= 1'b1;
                    ent_q[i].rtime <= now;
                end
            end
        end
    end

    a_r11_full_blocks_insert: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !ins_en);
    a_r8_delete_needs_match: assert property (@(posedge clk) disable iff (rst)
        del_en |-> hit_o);
    a_r1_insert_grows_queue: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/rdt_query.sv
module rdt_query
    import rdt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_ent_t [DEPTH-1:0] ent,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [SEQ_W-1:0]    q_seq,
    input  logic [TIME_W-1:0]   now,
    output logic                rd_ok,
    output logic                fwd_valid,
    output logic [SEQ_W-1:0]    fwd_seq
);
    wr_ent_t sel;
    logic    found;
    logic    stop;

    assign rd_ok = (cnt == '0) || (q_seq <= ent[0].seq);

    always_comb begin
        sel   = '0;
        found = 1'b0;
        stop  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && (CNT_W'(i) < cnt)) begin
                if (ent[i].seq < q_seq) begin
                    found = 1'b1;
                    sel   = ent[i];
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    assign fwd_valid = found && sel.done && (sel.rtime < now);
    assign fwd_seq   = fwd_valid ? sel.seq : '0;

    a_r6_fwd_means_read_blocked: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !rd_ok);
endmodule

// File: rtl/rdt_scoreboard.sv
module rdt_scoreboard
    import rdt_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                cmd_op,
    input  logic [SEQ_W-1:0]          cmd_seq,
    input  logic                      cmd_tracked,
    input  logic                      d0_valid,
    input  logic [1:0]                d0_cls,
    input  logic [$clog2(NREG)-1:0]   d0_idx,
    input  logic                      d1_valid,
    input  logic [1:0]                d1_cls,
    input  logic [$clog2(NREG)-1:0]   d1_idx,
    input  logic [SEQ_W-1:0]          q_seq,
    input  logic [1:0]                q_cls,
    input  logic [$clog2(NREG)-1:0]   q_idx,
    output logic                      ins_stall,
    output logic                      ins_tracked,
    output logic                      rm_clear,
    output logic                      cmd_err,
    output logic                      q_read_ok,
    output logic                      q_write_ok,
    output logic                      q_fwd_valid,
    output logic [SEQ_W-1:0]          q_fwd_seq
);
    localparam int NQ    = NUM_CLS * NREG;
    localparam int QW    = $clog2(NQ);
    localparam int CNT_W = $clog2(DEPTH + 1);

    op_e               op;
    logic              live0, live1, same_reg, pop_tgt, pop_ok;
    logic              stall, ins_go, miss, rm_go, q_in_range;
    logic [QW-1:0]     t0, t1, qt;
    logic [TIME_W-1:0] now_q;

    logic [NQ-1:0]       full, hit, head_hit, ins_en, del_en;
    wr_ent_t [DEPTH-1:0] ents [NQ];
    logic [CNT_W-1:0]    cnts [NQ];
    wr_ent_t [DEPTH-1:0] sel_ent;
    logic [CNT_W-1:0]    sel_cnt;
    logic                rd_ok;

    assign op       = op_e'(cmd_op);
    assign t0       = QW'(int'(d0_cls) * NREG + int'(d0_idx));
    assign t1       = QW'(int'(d1_cls) * NREG + int'(d1_idx));
    assign qt       = QW'(int'(q_cls) * NREG + int'(q_idx));
    assign same_reg = (d1_cls == d0_cls) && (d1_idx == d0_idx);
    assign live0    = dest_live(d0_valid, d0_cls, d0_idx == '0);
    assign live1    = dest_live(d1_valid, d1_cls, d1_idx == '0) && !(live0 && same_reg);

    assign stall  = (op == OP_INSERT) && ((live0 && full[t0]) || (live1 && full[t1]));
    assign ins_go = (op == OP_INSERT) && !stall;
    assign miss   = (live0 && !hit[t0]) || (live1 && !hit[t1]);
    assign rm_go  = (op == OP_REMOVE) && cmd_tracked && !miss;
    assign pop_tgt = d0_valid && (d0_cls < 2'(NUM_CLS));
    assign pop_ok  = pop_tgt && head_hit[t0];

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic targeted;
        assign targeted  = (live0 && (t0 == QW'(g))) || (live1 && (t1 == QW'(g)));
        assign ins_en[g] = ins_go && targeted;
        assign del_en[g] = (rm_go && targeted)
                         || ((op == OP_POP) && pop_ok && (t0 == QW'(g)));
        rdt_wq #(.DEPTH(DEPTH)) u_wq (
            .clk        (clk),
            .rst        (rst),
            .ins_en     (ins_en[g]),
            .del_en     (del_en[g]),
            .wb_en      (op == OP_WBACK),
            .tag        (cmd_seq),
            .now        (now_q),
            .ent_o      (ents[g]),
            .cnt_o      (cnts[g]),
            .full_o     (full[g]),
            .hit_o      (hit[g]),
            .head_hit_o (head_hit[g])
        );
    end

    assign q_in_range = (q_cls < 2'(NUM_CLS));
    assign sel_ent    = q_in_range ? ents[qt] : '0;
    assign sel_cnt    = q_in_range ? cnts[qt] : '0;

    rdt_query #(.DEPTH(DEPTH)) u_query (
        .clk       (clk),
        .rst       (rst),
        .ent       (sel_ent),
        .cnt       (sel_cnt),
        .q_seq     (q_seq),
        .now       (now_q),
        .rd_ok     (rd_ok),
        .fwd_valid (q_fwd_valid),
        .fwd_seq   (q_fwd_seq)
    );

    assign q_read_ok   = rd_ok;
    assign q_write_ok  = rd_ok;
    assign ins_stall   = stall;
    assign ins_tracked = ins_go && (live0 || live1);
    assign rm_clear    = rm_go;
    assign cmd_err     = ((op == OP_REMOVE) && cmd_tracked && miss)
                       || ((op == OP_POP) && !pop_ok);

    a_r2_zero_reg_never_held: assert property (@(posedge clk) disable iff (rst)
        cnts[0] == '0);
    a_r10_clear_and_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rm_clear && cmd_err));
    a_r11_stall_only_on_insert: assert property (@(posedge clk) disable iff (rst)
        ins_stall |-> !ins_tracked);
endmodule

// File: tb/sim_rdt_scoreboard.sv
`timescale 1ns/1ps
module sim_rdt_scoreboard;
    localparam int NREG  = 8;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(NREG);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_seq = '0;
    logic cmd_tracked = 1'b0;
    logic d0_valid = 1'b0, d1_valid = 1'b0;
    logic [1:0] d0_cls = '0, d1_cls = '0, q_cls = '0;
    logic [IW-1:0] d0_idx = '0, d1_idx = '0, q_idx = '0;
    logic [7:0] q_seq = '0;
    logic ins_stall, ins_tracked, rm_clear, cmd_err;
    logic q_read_ok, q_write_ok, q_fwd_valid;
    logic [7:0] q_fwd_seq;

    always #4 clk = ~clk;

    rdt_scoreboard #(.NREG(NREG), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_seq(cmd_seq),
        .cmd_tracked(cmd_tracked), .d0_valid(d0_valid), .d0_cls(d0_cls),
        .d0_idx(d0_idx), .d1_valid(d1_valid), .d1_cls(d1_cls), .d1_idx(d1_idx),
        .q_seq(q_seq), .q_cls(q_cls), .q_idx(q_idx), .ins_stall(ins_stall),
        .ins_tracked(ins_tracked), .rm_clear(rm_clear), .cmd_err(cmd_err),
        .q_read_ok(q_read_ok), .q_write_ok(q_write_ok),
        .q_fwd_valid(q_fwd_valid), .q_fwd_seq(q_fwd_seq)
    );

    // reference model: per-register writer lists
    int ms [3][NREG][DEPTH];
    int md [3][NREG][DEPTH];
    int mt [3][NREG][DEPTH];
    int mc [3][NREG];
    int mnow = 0;
    int checks = 0, fails = 0, cyc = 0;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 3000) begin
            checks++; fails++;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <= 3000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit live(bit v, int c, int i);
        return v && c < 3 && !(c == 0 && i == 0);
    endfunction

    function automatic int find(int c, int i, int s);
        for (int k = 0; k < mc[c][i]; k++) if (ms[c][i][k] == s) return k;
        return -1;
    endfunction

    function automatic void del_at(int c, int i, int p);
        for (int k = p; k < DEPTH - 1; k++) begin
            ms[c][i][k] = ms[c][i][k+1]; md[c][i][k] = md[c][i][k+1]; mt[c][i][k] = mt[c][i][k+1];
        end
        mc[c][i]--;
    endfunction

    function automatic void push(int c, int i, int s);
        ms[c][i][mc[c][i]] = s; md[c][i][mc[c][i]] = 0; mt[c][i][mc[c][i]] = 0;
        mc[c][i]++;
    endfunction

    task automatic step(string tag, int op, int seq, bit trk,
                        bit v0, int c0, int i0, bit v1, int c1, int i1,
                        int qs, int qc, int qi);
        bit e0, e1, st, set_, clr, err, rd, fv;
        int fs, n, cand;
        @(negedge clk);
        cmd_op = 3'(op); cmd_seq = 8'(seq); cmd_tracked = trk;
        d0_valid = v0; d0_cls = 2'(c0); d0_idx = IW'(i0);
        d1_valid = v1; d1_cls = 2'(c1); d1_idx = IW'(i1);
        q_seq = 8'(qs); q_cls = 2'(qc); q_idx = IW'(qi);
        e0 = live(v0, c0, i0);
        e1 = live(v1, c1, i1) && !(e0 && c0 == c1 && i0 == i1);
        st = (op == 1) && ((e0 && mc[c0][i0] == DEPTH) || (e1 && mc[c1][i1] == DEPTH));
        set_ = (op == 1) && !st && (e0 || e1);
        err = 0; clr = 0;
        if (op == 2 && trk) begin
            err = (e0 && find(c0, i0, seq) < 0) || (e1 && find(c1, i1, seq) < 0);
            clr = !err;
        end
        if (op == 3)
            err = !(v0 && c0 < 3 && mc[c0][i0] > 0 && ms[c0][i0][0] == seq);
        rd = 1; fv = 0; fs = 0;
        if (qc < 3) begin
            n = mc[qc][qi];
            rd = (n == 0) || (qs <= ms[qc][qi][0]);
            cand = -1;
            for (int k = 0; k < n; k++) begin
                if (ms[qc][qi][k] < qs) cand = k;
                else break;
            end
            if (cand >= 0 && md[qc][qi][cand] != 0 && mt[qc][qi][cand] < mnow) begin
                fv = 1; fs = ms[qc][qi][cand];
            end
        end
        #1;
        chk(tag, "ins_stall (R11)", int'(ins_stall), int'(st));
        chk(tag, "ins_tracked (R10)", int'(ins_tracked), int'(set_));
        chk(tag, "rm_clear (R10)", int'(rm_clear), int'(clr));
        chk(tag, "cmd_err (R8/R9)", int'(cmd_err), int'(err));
        chk(tag, "q_read_ok (R4)", int'(q_read_ok), int'(rd));
        chk(tag, "q_write_ok (R5)", int'(q_write_ok), int'(rd));
        chk(tag, "q_fwd_valid (R7)", int'(q_fwd_valid), int'(fv));
        chk(tag, "q_fwd_seq (R6)", int'(q_fwd_seq), fs);
        @(posedge clk);
        case (op)
            1: if (!st) begin
                   if (e0) push(c0, i0, seq);
                   if (e1) push(c1, i1, seq);
               end
            2: if (trk && !err) begin
                   if (e0) del_at(c0, i0, find(c0, i0, seq));
                   if (e1) del_at(c1, i1, find(c1, i1, seq));
               end
            3: if (!err) del_at(c0, i0, 0);
            4: for (int c = 0; c < 3; c++)
                   for (int r = 0; r < NREG; r++)
                       for (int k = 0; k < mc[c][r]; k++)
                           if (ms[c][r][k] == seq && md[c][r][k] == 0) begin
                               md[c][r][k] = 1; mt[c][r][k] = mnow;
                           end
            default: ;
        endcase
        mnow++;
    endtask

    initial begin
        for (int c = 0; c < 3; c++) for (int r = 0; r < NREG; r++) mc[c][r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mnow = 0;
        // reset state: everything empty (R12 / R4)
        step("R12_reset", 0, 0, 0, 0,0,0, 0,0,0, 5, 0, 3);
        // R1: insert two destinations; same-cycle query still sees empty (R12)
        step("R1_insert", 1, 10, 0, 1,0,3, 1,1,1, 20, 0, 3);
        step("R4_blocked", 0, 0, 0, 0,0,0, 0,0,0, 20, 0, 3);
        step("R4_equal_seq", 0, 0, 0, 0,0,0, 0,0,0, 10, 0, 3);
        step("R5_fp_reg", 0, 0, 0, 0,0,0, 0,0,0, 10, 1, 1);
        step("R1_append", 1, 12, 0, 1,0,3, 0,0,0, 13, 0, 3);
        step("R3_same_reg", 1, 14, 0, 1,0,3, 1,0,3, 15, 0, 3);
        // R7: writeback; same cycle query not yet forwardable
        step("R7_wb_same_cycle", 4, 12, 0, 0,0,0, 0,0,0, 13, 0, 3);
        step("R7_after_wb", 0, 0, 0, 0,0,0, 0,0,0, 13, 0, 3);
        step("R6_youngest_older", 0, 0, 0, 0,0,0, 0,0,0, 15, 0, 3);
        step("R7_wb14", 4, 14, 0, 0,0,0, 0,0,0, 15, 0, 3);
        step("R6_fwd14", 0, 0, 0, 0,0,0, 0,0,0, 15, 0, 3);
        step("R6_stop_scan", 0, 0, 0, 0,0,0, 0,0,0, 200, 0, 3);
        // R11: fill and overflow
        step("R11_fill", 1, 16, 0, 1,0,3, 0,0,0, 15, 0, 3);
        step("R11_stall", 1, 18, 0, 1,0,3, 1,2,2, 30, 2, 2);
        step("R11_no_change", 0, 0, 0, 0,0,0, 0,0,0, 30, 2, 2);
        step("R11_head_kept", 0, 0, 0, 0,0,0, 0,0,0, 200, 0, 3);
        // R2: integer zero register
        step("R2_zero_insert", 1, 20, 0, 1,0,0, 0,0,0, 50, 0, 0);
        step("R2_zero_empty", 0, 0, 0, 0,0,0, 0,0,0, 50, 0, 0);
        // R8: remove from the middle
        step("R8_remove_mid", 2, 12, 1, 1,0,3, 0,0,0, 13, 0, 3);
        step("R8_after_remove", 0, 0, 0, 0,0,0, 0,0,0, 13, 0, 3);
        step("R8_fwd_kept", 0, 0, 0, 0,0,0, 0,0,0, 15, 0, 3);
        step("R8_missing_tag", 2, 99, 1, 1,0,3, 1,1,1, 15, 0, 3);
        step("R8_no_change", 0, 0, 0, 0,0,0, 0,0,0, 11, 1, 1);
        // R10: untracked remove is ignored
        step("R10_untracked", 2, 14, 0, 1,0,3, 0,0,0, 15, 0, 3);
        step("R10_still_there", 0, 0, 0, 0,0,0, 0,0,0, 15, 0, 3);
        // R9: pops
        step("R9_head_mismatch", 3, 14, 0, 1,0,3, 0,0,0, 11, 0, 3);
        step("R9_pop_ok", 3, 10, 0, 1,0,3, 0,0,0, 11, 0, 3);
        step("R9_after_pop", 0, 0, 0, 0,0,0, 0,0,0, 11, 0, 3);
        step("R9_pop_empty", 3, 5, 0, 1,1,5, 0,0,0, 0, 3, 0);
        step("R9_pop_bad_class", 3, 5, 0, 1,3,0, 0,0,0, 5, 3, 1);
        // R2 + R8: remove skipping integer zero
        step("R2_remove_zero", 2, 10, 1, 1,0,0, 1,1,1, 11, 1, 1);
        step("R8_fp_empty", 0, 0, 0, 0,0,0, 0,0,0, 11, 1, 1);
        // R3: remove with duplicated destination
        step("R3_remove_dup", 2, 14, 1, 1,0,3, 1,0,3, 15, 0, 3);
        step("R3_after", 0, 0, 0, 0,0,0, 0,0,0, 17, 0, 3);
        summary();
        $finish;
    end
endmodule